// File: doc/BRIEF.md
# Wait-State Memory Controller with Read Cache

This controller sits between a 16-bit byte-addressed CPU port and a slow memory array that cannot complete a read or write within one cycle of the system clock. Software sets a 3-bit wait-state count in a control register. Any access that must reach the array is held for that many extra cycles before the CPU sees ready. The rule of thumb is one wait state for a system clock above 8 MHz, and none at or below 8 MHz.

A small read cache holds four 64-bit lines, arranged as two sets of two ways. A read that falls in a cached line is answered in the cycle of the request, with no array access. A read miss fetches the whole line from the array in one access, places it in the least-recently-used way of its set and returns the requested word. Writes always go through to the array. If the written line is cached, its copy is patched so that later reads stay coherent. Changing the wait-state count flushes the cache.

Throughput therefore follows the relation: effective clock = system clock / (waits × miss ratio + 1). For example, one wait state with 75% hits at 16 MHz gives 12.8 MHz.

Top module: `ws_cache_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, ready is low without a request, and no line is valid, so the first read misses.
- R2: The wait-state count N is bits 6:4 of the control register. Writing 0x0010 selects N=1 and reads back 0x0010. All other bits read as 0, so writing 0xFFFF reads back 0x0070.
- R3: A read miss keeps mem_en high and ready low for N cycles after the request cycle. Ready is high in cycle N (cycle 0 is the request cycle, so N=0 completes in the request cycle). The returned word is bits [16·a+15 : 16·a] of mem_rdata, where a = address bits 2:1.
- R4: A read hit asserts ready in the request cycle with mem_en low and returns the cached word.
- R5: Address bit 3 selects the set, and bits AW-1:4 form the tag. Two lines with different tags in the same set are both cached at once.
- R6: A miss fills the least-recently-used way of its set. Each fill or hit marks that way as most recently used.
- R7: A write takes N wait cycles like a miss, never hits, and asserts mem_we with mem_wsel equal to address bits 2:1 and mem_wdata in its ready cycle.
- R8: A write to a cached line updates the cached word, so a later read hit returns the written data.
- R9: A control write that changes N invalidates all four lines. A write of the same value leaves the cache intact.
- R10: An access uses the N in force when it starts, so a change during an access does not alter that access. A flush in the same cycle as a line fill wins, and the line is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| cpu_req | input | 1 | CPU request, held with its fields until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data, valid with ready |
| cpu_ready | output | 1 | One-cycle completion of the current request |
| mem_en | output | 1 | Array access in progress |
| mem_we | output | 1 | Array word write, in the completion cycle |
| mem_addr | output | AW-3 | Array line address |
| mem_wsel | output | 2 | Word within the line for a write |
| mem_wdata | output | 16 | Array write data |
| mem_rdata | input | 64 | Array line data for mem_addr |

## Verification
The two functions that can fall in the same cycle are a line fill at the end of a read miss and the flush caused by a control write that changes the wait-state count. The bench starts a three-wait read miss and times a control write to land exactly in its completion cycle. The outcome is judged at the ports in two ways. The in-flight read must still take three cycles with the old count, and a repeat read of the same line must miss and take the new count's latency before a third read hits.

// File: rtl/ws_cache_ctrl.sv
module ws_cache_ctrl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic [15:0]   cpu_rdata,
  output logic          cpu_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-4:0] mem_addr,
  output logic [1:0]    mem_wsel,
  output logic [15:0]   mem_wdata,
  input  logic [63:0]   mem_rdata
);
  localparam int TW = AW - 4;

  logic [2:0]    nwait_q;
  logic          busy_q;
  logic [2:0]    cnt_q;
  logic [1:0]    vld_q [2];
  logic [1:0]    lru_q;
  logic [63:0]   line_q [2][2];
  logic [TW-1:0] tag_q [2][2];

  logic          set_i;
  logic [1:0]    wsel;
  logic [TW-1:0] tag_i;
  logic          hit0, hit1, rd_hit, start, hit_start, done_arr, inval;
  logic          victim;
  logic [63:0]   hit_line, src_line;
  logic          unused_bits;

  assign set_i     = cpu_addr[3];
  assign wsel      = cpu_addr[2:1];
  assign tag_i     = cpu_addr[AW-1:4];
  assign hit0      = vld_q[set_i][0] && (tag_q[set_i][0] == tag_i);
  assign hit1      = vld_q[set_i][1] && (tag_q[set_i][1] == tag_i);
  assign rd_hit    = !cpu_we && (hit0 || hit1);
  assign start     = cpu_req && !busy_q;
  assign hit_start = start && rd_hit;
  assign done_arr  = (start && !rd_hit && nwait_q == 3'd0) || (busy_q && cnt_q == 3'd0);
  assign inval     = cfg_we && (cfg_wdata[6:4] != nwait_q);
  assign victim    = lru_q[set_i];
  assign hit_line  = hit1 ? line_q[set_i][1] : line_q[set_i][0];
  assign src_line  = hit_start ? hit_line : mem_rdata;

  assign cfg_rdata = {9'd0, nwait_q, 4'd0};
  assign cpu_rdata = src_line[wsel*16 +: 16];
  assign cpu_ready = hit_start || done_arr;
  assign mem_en    = (start && !rd_hit) || busy_q;
  assign mem_we    = done_arr && cpu_we;
  assign mem_addr  = cpu_addr[AW-1:3];
  assign mem_wsel  = wsel;
  assign mem_wdata = cpu_wdata;
  assign unused_bits = ^{cpu_addr[0], cfg_wdata[15:7], cfg_wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nwait_q <= 3'd0;
      busy_q  <= 1'b0;
      cnt_q   <= 3'd0;
    end else begin
      if (cfg_we) nwait_q <= cfg_wdata[6:4];
      if (busy_q) begin
        if (cnt_q == 3'd0) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q - 3'd1;
      end else if (start && !rd_hit && nwait_q != 3'd0) begin
        busy_q <= 1'b1;
        cnt_q  <= nwait_q - 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q[0] <= 2'b00;
      vld_q[1] <= 2'b00;
      lru_q    <= 2'b00;
    end else if (inval) begin
      vld_q[0] <= 2'b00;
      vld_q[1] <= 2'b00;
    end else if (done_arr && !cpu_we) begin
      vld_q[set_i][victim] <= 1'b1;
      lru_q[set_i]         <= ~victim;
    end else if (hit_start) begin
      lru_q[set_i] <= hit0;
    end
  end

  always_ff @(posedge clk) begin
    if (done_arr && !cpu_we && !inval) begin
      line_q[set_i][victim] <= mem_rdata;
      tag_q[set_i][victim]  <= tag_i;
    end else if (done_arr && cpu_we) begin
      if (hit0) line_q[set_i][0][wsel*16 +: 16] <= cpu_wdata;
      if (hit1) line_q[set_i][1][wsel*16 +: 16] <= cpu_wdata;
    end
  end
endmodule

module ws_cache_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [15:0]   cfg_wdata,
  input logic [15:0]   cfg_rdata,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-4:0] mem_addr
);
  logic unused_chk;
  assign unused_chk = ^{cfg_wdata[15:7], cfg_wdata[3:0], cfg_rdata[15:7], cfg_rdata[3:0]};

  p_cfg_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[6:4] == $past(cfg_wdata[6:4]));
  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);
  p_hold_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !cpu_ready) |=> (mem_en && $stable(mem_addr)));
  p_hit_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !mem_en) |-> !cpu_we);
  p_write_reaches_array_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> (mem_we && mem_en));
  p_mem_we_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> cpu_ready);
  p_no_hit_after_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[6:4] != cfg_rdata[6:4]) |=> !(cpu_ready && !mem_en));
endmodule

bind ws_cache_ctrl ws_cache_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_ready(cpu_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tb_ws_cache_ctrl.sv
`timescale 1ns/1ps
module tb_ws_cache_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        cpu_req = 0, cpu_we = 0;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0;
  logic [15:0] cpu_rdata;
  logic        cpu_ready, mem_en, mem_we;
  logic [12:0] mem_addr;
  logic [1:0]  mem_wsel;
  logic [15:0] mem_wdata;
  logic [63:0] mem_rdata;

  always #5 clk = ~clk;

  ws_cache_ctrl #(.AW(16)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wsel(mem_wsel), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] init_word(int l, int w);
    return {l[7:0], 6'd0, w[1:0]} ^ 16'h3C00;
  endfunction

  logic [63:0] mem_line [256];
  logic [15:0] shadow [1024];
  initial begin
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 4; w++) mem_line[i][w*16 +: 16] = init_word(i, w);
    for (int i = 0; i < 1024; i++) shadow[i] = init_word(i >> 2, i & 3);
  end
  assign mem_rdata = mem_line[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem_line[mem_addr[7:0]][mem_wsel*16 +: 16] <= mem_wdata;

  int cyc = 0, start_cyc = 0, total = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
    int          lat;
    logic        hit;
    string       req;
  } item_t;
  item_t sb[$];

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cpu_ready) begin
      if (sb.size() == 0) chk(0, "R3", "unexpected ready", 1, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(cyc - start_cyc == it.lat, it.req, "latency", cyc - start_cyc, it.lat);
        chk(mem_en == !it.hit, it.req, "mem_en at ready", mem_en, !it.hit);
        if (!it.we) chk(cpu_rdata == it.data, it.req, "read data", cpu_rdata, it.data);
        else begin
          chk(mem_we == 1'b1, it.req, "mem_we", mem_we, 1);
          chk(mem_wdata == it.data && mem_wsel == it.addr[2:1], it.req, "write word",
              mem_wdata, it.data);
        end
      end
    end
  end

  task automatic access(input logic we, input logic [15:0] addr, input logic [15:0] wd,
                        input int lat, input logic hit, input string r);
    item_t it;
    it.we = we; it.addr = addr; it.lat = lat; it.hit = hit; it.req = r;
    it.data = we ? wd : shadow[addr[10:1]];
    if (we) shadow[addr[10:1]] = wd;
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    start_cyc = cyc;
    sb.push_back(it);
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic cfg_write(input logic [15:0] d, input logic [15:0] exp, input string r);
    @(posedge clk); #1; cfg_we = 1; cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 0;
    @(negedge clk);
    chk(cfg_rdata == exp, r, "control readback", cfg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cfg_rdata == 16'h0000, "R1", "reset register", cfg_rdata, 0);
    chk(cpu_ready == 1'b0, "R1", "reset ready", cpu_ready, 0);

    cfg_write(16'hFFFF, 16'h0070, "R2");
    cfg_write(16'h0010, 16'h0010, "R2");

    access(0, 16'h0000, 0, 1, 0, "R1");
    access(0, 16'h0002, 0, 0, 1, "R4");
    access(0, 16'h0006, 0, 0, 1, "R4");
    access(0, 16'h0008, 0, 1, 0, "R3");
    access(0, 16'h000C, 0, 0, 1, "R4");
    access(0, 16'h0010, 0, 1, 0, "R5");
    access(0, 16'h0000, 0, 0, 1, "R5");
    access(0, 16'h0014, 0, 0, 1, "R5");
    access(0, 16'h0000, 0, 0, 1, "R6");
    access(0, 16'h0020, 0, 1, 0, "R6");
    access(0, 16'h0000, 0, 0, 1, "R6");
    access(0, 16'h0010, 0, 1, 0, "R6");
    access(0, 16'h0020, 0, 1, 0, "R6");

    access(1, 16'h0012, 16'hBEEF, 1, 0, "R7");
    access(0, 16'h0012, 0, 0, 1, "R8");
    access(1, 16'h0042, 16'h1234, 1, 0, "R7");
    access(0, 16'h0042, 0, 1, 0, "R7");

    cfg_write(16'h0030, 16'h0030, "R9");
    access(0, 16'h0012, 0, 3, 0, "R9");
    cfg_write(16'h0030, 16'h0030, "R9");
    access(0, 16'h0012, 0, 0, 1, "R9");

    fork
      access(0, 16'h0008, 0, 3, 0, "R10");
      begin
        @(posedge clk);
        repeat (3) @(posedge clk);
        #1 cfg_we = 1; cfg_wdata = 16'h0010;
        @(posedge clk); #1 cfg_we = 0;
      end
    join
    access(0, 16'h0008, 0, 1, 0, "R10");
    access(0, 16'h0008, 0, 0, 1, "R10");

    cfg_write(16'h0000, 16'h0000, "R3");
    access(0, 16'h0018, 0, 0, 0, "R3");
    access(0, 16'h0018, 0, 0, 1, "R4");
    access(1, 16'h001A, 16'h7E57, 0, 0, "R7");
    access(0, 16'h001A, 0, 0, 1, "R8");

    repeat (2) @(posedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule